// File: doc/BRIEF.md
# March Memory Self-Test Controller

This block is a built-in self-test sequencer for a one-bit-wide synchronous RAM. A start pulse launches one of two march algorithms, chosen by a select input. March C- has ten operations per cell. March B has seventeen operations per cell.

A march element is a short list of reads and writes. The controller applies the whole list to one cell, then moves to the next cell. Each element walks the whole address space, either upward or downward, before the next element begins. The RAM returns read data one clock after the read strobe, and the controller compares it with the expected bit in that cycle. The first mismatch sets a fail flag that stays set, and freezes the failing address and the element number.

A counter of the operations issued is visible at the ports, so the test length can be confirmed. The controller raises busy while it runs. At the end it drops busy and pulses done for one cycle.

Top module: `mbist_march`

## Requirements
- R1: With `alg_sel_i`=0 the elements run in this order: up(w0); up(r0,w1); up(r1,w0); down(r0,w1); down(r1,w0); up(r0). Elements are numbered from 0.
- R2: With `alg_sel_i`=1 the elements run in this order: up(w0); up(r0,w1,r1,w0,r0,w1); up(r1,w0,w1); down(r1,w0,w1,w0); down(r0,w1,w0).
- R3: All operations of an element are issued, one per cycle, on a single address before the address moves. Only one of `ram_we_o` and `ram_re_o` is high in a cycle, and both are low when the block is not running.
- R4: An up element starts at address 0 and ends at 2^AW-1. A down element starts at 2^AW-1 and ends at 0. The next element starts only after every cell has been visited.
- R5: A read is compared with `ram_rdata_i` in the cycle after its strobe. r0 expects 0 and r1 expects 1. Any mismatch sets `fail_o`, which stays set until the next accepted start.
- R6: `fail_addr_o` and `fail_elem_o` hold the address and element number of the first mismatch. Later mismatches leave them unchanged.
- R7: When done is high, `op_count_o` equals 10·2^AW for algorithm 0 and 17·2^AW for algorithm 1.
- R8: The controller is busy for exactly the number of operations plus one cycle. `done_o` is a one-cycle pulse, and `busy_o` is low while it is high.
- R9: A start pulse while busy is ignored. The running algorithm, its operation stream and its timing are unchanged.
- R10: After reset, busy, done, fail, both strobes and the operation count are 0.
- R11: A stuck-at cell, a transition fault and an up-transition inversion coupling fault between two cells are all detected by both algorithms. A fault-free memory passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| alg_sel_i | input | 1 | 0 = March C-, 1 = March B |
| ram_addr_o | output | AW | RAM address |
| ram_we_o | output | 1 | RAM write enable |
| ram_wdata_o | output | 1 | RAM write bit |
| ram_re_o | output | 1 | RAM read strobe |
| ram_rdata_i | input | 1 | RAM read bit, valid one cycle after the strobe |
| busy_o | output | 1 | Test running |
| done_o | output | 1 | One-cycle end-of-test pulse |
| fail_o | output | 1 | Sticky mismatch flag |
| fail_addr_o | output | AW | Address of the first mismatch |
| fail_elem_o | output | 3 | Element number of the first mismatch |
| op_count_o | output | AW+5 | Operations issued in the current or last run |

## Verification
The assertions assume that the RAM answers every read strobe with exactly one registered bit in the next cycle. They also assume that start is a level sampled only on clock edges, so a start held high during a run simply keeps being ignored.

The bench keeps to these assumptions. Its RAM model registers read data on the clock edge that follows the strobe. It changes start and the algorithm select only at falling edges, including the extra start pulse issued in the middle of a run. Fault sites and initial memory contents are drawn from a seeded random source. The expected outcome comes from a bench-side replay of the algorithm over the same faulty model.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  typedef enum logic {ALG_CMINUS = 1'b0, ALG_B = 1'b1} alg_e;

  // {is_write, bit}
  typedef enum logic [1:0] {
    OP_R0 = 2'b00, OP_R1 = 2'b01, OP_W0 = 2'b10, OP_W1 = 2'b11
  } op_e;

  localparam int ELEM_W = 3;
  localparam int IDX_W  = 3;

  // operation i sits in bits [2i+1:2i]
  function automatic logic [11:0] elem_word(alg_e a, logic [ELEM_W-1:0] e);
    logic [11:0] w;
    w = '0;
    if (a == ALG_B) begin
      case (e)
        3'd0: w = {10'b0, OP_W0};
        3'd1: w = {OP_W1, OP_R0, OP_W0, OP_R1, OP_W1, OP_R0};
        3'd2: w = {6'b0, OP_W1, OP_W0, OP_R1};
        3'd3: w = {4'b0, OP_W0, OP_W1, OP_W0, OP_R1};
        3'd4: w = {6'b0, OP_W0, OP_W1, OP_R0};
        default: w = '0;
      endcase
    end else begin
      case (e)
        3'd0: w = {10'b0, OP_W0};
        3'd1: w = {8'b0, OP_W1, OP_R0};
        3'd2: w = {8'b0, OP_W0, OP_R1};
        3'd3: w = {8'b0, OP_W1, OP_R0};
        3'd4: w = {8'b0, OP_W0, OP_R1};
        3'd5: w = {10'b0, OP_R0};
        default: w = '0;
      endcase
    end
    return w;
  endfunction

  function automatic logic [IDX_W-1:0] elem_len(alg_e a, logic [ELEM_W-1:0] e);
    logic [IDX_W-1:0] n;
    if (a == ALG_B) begin
      case (e)
        3'd0: n = 3'd1;
        3'd1: n = 3'd6;
        3'd2: n = 3'd3;
        3'd3: n = 3'd4;
        default: n = 3'd3;
      endcase
    end else begin
      n = (e == 3'd0 || e == 3'd5) ? 3'd1 : 3'd2;
    end
    return n;
  endfunction

  // same elements run downward in both algorithms
  function automatic logic elem_down(logic [ELEM_W-1:0] e);
    return (e == 3'd3) || (e == 3'd4);
  endfunction

  function automatic logic [ELEM_W-1:0] last_elem(alg_e a);
    return (a == ALG_B) ? 3'd4 : 3'd5;
  endfunction

endpackage

// File: rtl/march_addr.sv
module march_addr #(
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          load_down_i,
  input  logic          step_i,
  input  logic          down_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  localparam logic [AW-1:0] ADDR_MAX = '1;

  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (load_i)  addr_q <= load_down_i ? ADDR_MAX : '0;
    else if (step_i)  addr_q <= down_i ? addr_q - AW'(1) : addr_q + AW'(1);
  end

  assign addr_o = addr_q;
  assign last_o = addr_q == (down_i ? '0 : ADDR_MAX);

  a_r4_load_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (addr_q == '0 || addr_q == ADDR_MAX));
endmodule

// File: rtl/march_seq.sv
module march_seq
  import mbist_pkg::*;
#(
  parameter int AW = 6,
  localparam int CW = AW + 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              alg_sel_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              clear_o,
  output logic              we_o,
  output logic              re_o,
  output logic              wdata_o,
  output logic [AW-1:0]     addr_o,
  output logic [ELEM_W-1:0] elem_o,
  output logic [CW-1:0]     count_o
);
  localparam int N = 1 << AW;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FLUSH} st_e;

  st_e               st_q;
  alg_e              alg_q;
  logic [ELEM_W-1:0] elem_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CW-1:0]     count_q;
  logic              done_q;

  logic       run, start_ok, op_last, addr_last, elem_last;
  logic       addr_load, addr_load_down, addr_step;
  logic [11:0] word;
  op_e        op_cur;

  assign run       = st_q == S_RUN;
  assign start_ok  = st_q == S_IDLE && start_i;
  assign word      = elem_word(alg_q, elem_q);
  assign op_cur    = op_e'(word[int'(idx_q)*2 +: 2]);
  assign op_last   = (idx_q + 3'd1) == elem_len(alg_q, elem_q);
  assign elem_last = elem_q == last_elem(alg_q);

  assign addr_load      = start_ok || (run && op_last && addr_last && !elem_last);
  assign addr_load_down = start_ok ? elem_down(3'd0) : elem_down(elem_q + 3'd1);
  assign addr_step      = run && op_last && !addr_last;

  march_addr #(.AW(AW)) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (addr_load),
    .load_down_i (addr_load_down),
    .step_i      (addr_step),
    .down_i      (elem_down(elem_q)),
    .addr_o      (addr_o),
    .last_o      (addr_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      alg_q   <= ALG_CMINUS;
      elem_q  <= '0;
      idx_q   <= '0;
      count_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= st_q == S_FLUSH;
      case (st_q)
        S_IDLE: if (start_i) begin
          st_q    <= S_RUN;
          alg_q   <= alg_e'(alg_sel_i);
          elem_q  <= '0;
          idx_q   <= '0;
          count_q <= '0;
        end
        S_RUN: begin
          count_q <= count_q + CW'(1);
          if (!op_last) idx_q <= idx_q + 3'd1;
          else begin
            idx_q <= '0;
            if (addr_last) begin
              if (elem_last) st_q <= S_FLUSH;  // wait for the final read compare
              else           elem_q <= elem_q + 3'd1;
            end
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o  = st_q != S_IDLE;
  assign done_o  = done_q;
  assign clear_o = start_ok;
  assign we_o    = run && op_cur[1];
  assign re_o    = run && !op_cur[1];
  assign wdata_o = run && op_cur[0];
  assign elem_o  = elem_q;
  assign count_o = count_q;

  a_r3_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({we_o, re_o}));
  a_r3_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> !we_o && !re_o);
  a_r3_cell_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && !op_last |=> $stable(addr_o));
  a_r7_op_total: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> count_q == ((alg_q == ALG_B) ? CW'(17 * N) : CW'(10 * N)));
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r9_alg_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(alg_q));
endmodule

// File: rtl/march_cmp.sv
module march_cmp
  import mbist_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              rd_i,
  input  logic              exp_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [ELEM_W-1:0] elem_i,
  input  logic              rdata_i,
  output logic              fail_o,
  output logic [AW-1:0]     fail_addr_o,
  output logic [ELEM_W-1:0] fail_elem_o
);
  logic              pend_q, exp_q, fail_q;
  logic [AW-1:0]     addr_q, faddr_q;
  logic [ELEM_W-1:0] elem_q, felem_q;
  logic              mism;

  // registered RAM: data of a read arrives one cycle later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      exp_q  <= 1'b0;
      addr_q <= '0;
      elem_q <= '0;
    end else begin
      pend_q <= rd_i;
      if (rd_i) begin
        exp_q  <= exp_i;
        addr_q <= addr_i;
        elem_q <= elem_i;
      end
    end
  end

  assign mism = pend_q && (rdata_i != exp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_q  <= 1'b0;
      faddr_q <= '0;
      felem_q <= '0;
    end else if (clear_i) begin
      fail_q  <= 1'b0;
      faddr_q <= '0;
      felem_q <= '0;
    end else if (mism && !fail_q) begin
      fail_q  <= 1'b1;
      faddr_q <= addr_q;
      felem_q <= elem_q;
    end
  end

  assign fail_o      = fail_q;
  assign fail_addr_o = faddr_q;
  assign fail_elem_o = felem_q;

  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_q && !clear_i |=> fail_q);
  a_r5_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_q) |-> $past(pend_q));
  a_r6_first_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_q && !clear_i |=> $stable(faddr_q) && $stable(felem_q));
endmodule

// File: rtl/mbist_march.sv
module mbist_march
  import mbist_pkg::*;
#(
  parameter int AW = 6,
  localparam int CW = AW + 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          alg_sel_i,
  output logic [AW-1:0] ram_addr_o,
  output logic          ram_we_o,
  output logic          ram_wdata_o,
  output logic          ram_re_o,
  input  logic          ram_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o,
  output logic [AW-1:0] fail_addr_o,
  output logic [2:0]    fail_elem_o,
  output logic [CW-1:0] op_count_o
);
  logic              clear;
  logic [ELEM_W-1:0] elem;

  march_seq #(.AW(AW)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .alg_sel_i (alg_sel_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .clear_o   (clear),
    .we_o      (ram_we_o),
    .re_o      (ram_re_o),
    .wdata_o   (ram_wdata_o),
    .addr_o    (ram_addr_o),
    .elem_o    (elem),
    .count_o   (op_count_o)
  );

  march_cmp #(.AW(AW)) u_cmp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear),
    .rd_i        (ram_re_o),
    .exp_i       (ram_wdata_o_exp(ram_re_o, ram_we_o, u_seq.op_cur)),
    .addr_i      (ram_addr_o),
    .elem_i      (elem),
    .rdata_i     (ram_rdata_i),
    .fail_o      (fail_o),
    .fail_addr_o (fail_addr_o),
    .fail_elem_o (fail_elem_o)
  );

  // expected bit of a read is the value field of the current operation
  function automatic logic ram_wdata_o_exp(logic re, logic we, op_e op);
    return (re || we) && op[0];
  endfunction

  a_r3_run_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_o || ram_re_o) |-> busy_o);
endmodule

// File: tb/sim_mbist_march.sv
`timescale 1ns/1ps
module sim_mbist_march;
  localparam int AW = 6;
  localparam int N  = 1 << AW;
  localparam int CW = AW + 5;

  logic clk = 1'b0, rst_ni = 1'b0, start = 1'b0, alg_sel = 1'b0;
  logic [AW-1:0] ram_addr;
  logic ram_we, ram_wdata, ram_re, ram_rdata;
  logic busy, done, fail;
  logic [AW-1:0] fail_addr;
  logic [2:0] fail_elem;
  logic [CW-1:0] op_count;

  always #5 clk = ~clk;

  mbist_march #(.AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .alg_sel_i(alg_sel),
    .ram_addr_o(ram_addr), .ram_we_o(ram_we), .ram_wdata_o(ram_wdata),
    .ram_re_o(ram_re), .ram_rdata_i(ram_rdata), .busy_o(busy), .done_o(done),
    .fail_o(fail), .fail_addr_o(fail_addr), .fail_elem_o(fail_elem),
    .op_count_o(op_count)
  );

  int checks = 0, errors = 0;

  // fault model: 0 none, 1 stuck-at, 2 transition (fails to reach f_val), 3 up-inversion coupling
  int flt_kind = 0, f_a = 0, f_v = 0;
  logic f_val = 1'b0;
  logic [N-1:0] mem;

  function automatic logic rd_f(logic [N-1:0] m, int a);
    if (flt_kind == 1 && a == f_a) return f_val;
    return m[a];
  endfunction

  function automatic logic [N-1:0] wr_f(logic [N-1:0] m, int a, logic d);
    logic [N-1:0] r = m;
    if (flt_kind == 2 && a == f_a && m[a] != d && d == f_val) return r;
    r[a] = d;
    if (flt_kind == 3 && a == f_a && !m[a] && d) r[f_v] = ~r[f_v];
    return r;
  endfunction

  always @(posedge clk) begin
    if (ram_we) mem <= wr_f(mem, int'(ram_addr), ram_wdata);
    if (ram_re) ram_rdata <= rd_f(mem, int'(ram_addr));
  end

  function automatic string el_str(int alg, int e);
    if (alg == 1) begin
      case (e)
        0: return "w0";
        1: return "r0w1r1w0r0w1";
        2: return "r1w0w1";
        3: return "r1w0w1w0";
        default: return "r0w1w0";
      endcase
    end
    case (e)
      0: return "w0";
      1, 3: return "r0w1";
      2, 4: return "r1w0";
      default: return "r0";
    endcase
  endfunction

  function automatic int n_el(int alg);
    return alg == 1 ? 5 : 6;
  endfunction

  function automatic bit el_down(int e);
    return e == 3 || e == 4;
  endfunction

  function automatic int total_ops(int alg);
    return (alg == 1 ? 17 : 10) * N;
  endfunction

  // flat operation k -> address, write flag, bit
  function automatic void exp_op(int alg, int k, output int a, output bit w, output bit v);
    int kk = k;
    a = 0; w = 0; v = 0;
    for (int e = 0; e < n_el(alg); e++) begin
      string s = el_str(alg, e);
      int l = s.len() / 2;
      if (kk < l * N) begin
        int c = kk / l, i = kk % l;
        a = el_down(e) ? N - 1 - c : c;
        w = s[2*i] == "w";
        v = s[2*i+1] == "1";
        return;
      end
      kk -= l * N;
    end
  endfunction

  function automatic void ref_run(int alg, logic [N-1:0] m0, output bit rf, output int ra, output int re);
    logic [N-1:0] m = m0;
    rf = 0; ra = 0; re = 0;
    for (int e = 0; e < n_el(alg); e++) begin
      string s = el_str(alg, e);
      for (int c = 0; c < N; c++) begin
        int a = el_down(e) ? N - 1 - c : c;
        for (int i = 0; i < s.len() / 2; i++) begin
          bit v = s[2*i+1] == "1";
          if (s[2*i] == "w") m = wr_f(m, a, v);
          else if (rd_f(m, a) != v && !rf) begin rf = 1; ra = a; re = e; end
        end
      end
    end
  endfunction

  // stream monitor
  bit mon_on = 0;
  int mon_alg = 0, mon_k = 0, seq_err = 0, busy_cyc = 0;
  always @(negedge clk) if (mon_on) begin
    if (busy) busy_cyc++;
    if (ram_we || ram_re) begin
      int a; bit w, v;
      exp_op(mon_alg, mon_k, a, w, v);
      if (int'(ram_addr) != a || ram_we != w || ram_re == w || (w && ram_wdata != v)) begin
        if (seq_err == 0)
          $display("FAIL R3 stream op %0d: addr %0d we %0d d %0d, expected addr %0d we %0d d %0d",
                   mon_k, ram_addr, ram_we, ram_wdata, a, w, v);
        seq_err++;
      end
      mon_k++;
    end
  end

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic run(int alg, int kind, int fa, int fv, bit fval, bit mid, bit must_det);
    bit rf; int ra, re, t;
    flt_kind = kind; f_a = fa; f_v = fv; f_val = fval;
    @(negedge clk);
    for (int i = 0; i < N; i++) mem[i] = 1'($urandom);
    ref_run(alg, mem, rf, ra, re);
    alg_sel = alg[0]; start = 1;
    mon_alg = alg; mon_k = 0; seq_err = 0; busy_cyc = 0; mon_on = 1;
    @(negedge clk); start = 0;
    if (mid) begin
      repeat (100) @(negedge clk);
      alg_sel = ~alg[0]; start = 1;
      @(negedge clk); start = 0;
    end
    t = 0;
    while (!done && t < 4000) begin @(negedge clk); t++; end
    if (!done) begin
      check(0, "R8 watchdog", t, total_ops(alg));
      mon_on = 0;
      return;
    end
    check(seq_err == 0, alg == 1 ? "R2/R4 element stream" : "R1/R4 element stream", seq_err, 0);
    check(mon_k == total_ops(alg), "R7 strobe count", mon_k, total_ops(alg));
    check(int'(op_count) == total_ops(alg), "R7 op_count", int'(op_count), total_ops(alg));
    check(busy_cyc == total_ops(alg) + 1, mid ? "R9 busy length" : "R8 busy length",
          busy_cyc, total_ops(alg) + 1);
    check(!busy, "R8 busy at done", busy, 0);
    check(fail == rf, "R5 fail flag", fail, rf);
    if (rf) begin
      check(int'(fail_addr) == ra, "R6 fail address", int'(fail_addr), ra);
      check(int'(fail_elem) == re, "R6 fail element", int'(fail_elem), re);
    end
    if (must_det) check(fail, "R11 fault detected", fail, 1);
    if (kind == 0) check(!fail, "R11 clean memory passes", fail, 0);
    @(negedge clk);
    check(!done, "R8 done one cycle", done, 0);
    mon_on = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 200000 expected fewer cycles");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!busy && !done && !fail, "R10 status", {busy, done, fail}, 0);
    check(!ram_we && !ram_re, "R10 strobes", {ram_we, ram_re}, 0);
    check(op_count == 0, "R10 op_count", int'(op_count), 0);
    rst_ni = 1;
    for (int alg = 0; alg < 2; alg++) begin
      run(alg, 0, 0, 0, 0, 0, 0);
      run(alg, 1, 5, 0, 1, 0, 1);
      run(alg, 1, N - 1, 0, 0, 0, 1);
      run(alg, 2, 17, 0, 1, 0, 1);
      run(alg, 2, 40, 0, 0, 0, 1);
      run(alg, 3, 10, 50, 0, 0, 1);
      run(alg, 3, 50, 10, 0, 0, 1);
    end
    // R9 start while busy, both directions of the switch
    run(0, 0, 0, 0, 0, 1, 0);
    run(1, 1, 33, 0, 0, 1, 1);
    for (int r = 0; r < 6; r++) begin
      int k = 1 + int'($urandom % 3), a = int'($urandom % N), v = int'($urandom % N);
      if (v == a) v = (a + 1) % N;
      run(int'($urandom % 2), k, a, v, 1'($urandom), 0, 1);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule